// File: doc/BRIEF.md
# Per-Ply Capture Move Enumeration Sequencer

This block steps a combinational victim/aggressor move generator through every pseudo-legal move of a search ply, most valuable victim first and, for each victim, least valuable attacker first. The whole enumeration state of a ply is one 64-bit disable word. Bit s of every board-wide vector stands for square s. A victim search looks for the best target square whose bit is clear. Once a victim is chosen, the sequencer clears every own-piece bit so that all own squares can again be origins. It then runs aggressor searches against that victim. Each retired origin square is masked in turn. When no attacker is left, the victim square is masked and a new victim search begins.

The search controller sees each move as a from/to pair held with `move_valid`. For that move it makes the move, searches the subtree and unmakes the move, then reports `move_done`. A deeper search enters a child ply with `ply_push` while the parent move is held. The child leaves with `ply_pop`, which brings back the parent's suspended word, victim and origin. The generator port carries one request at a time. Each request is a level held until a one-cycle `gen_ack`.

Top module: `ply_move_sequencer`

## Requirements
- R1: After reset, `level` is 0 and `gen_req`, `move_valid`, `exhausted` and `overflow` are all 0.
- R2: A `ply_push` is accepted at level 0, or while a move is held below level DEPTH. It raises `level` by one. On the next cycle a victim search is requested (`gen_req`=1, `gen_find_agg`=0) with `gen_mask` all zero.
- R3: A request holds `gen_req`, `gen_find_agg` and `gen_mask` steady until a cycle with `gen_ack`=1. `gen_req` is 0 while a move is held or the ply is exhausted.
- R4: A victim search answered with `gen_found`=0 sets `exhausted`. It stays set until `ply_pop`.
- R5: A victim search answered with `gen_found`=1 and square t does two things. The mask becomes the old mask with every `own_pieces` bit cleared. The next request is an aggressor search (`gen_find_agg`=1) with `gen_target`=t.
- R6: An aggressor search answered with `gen_found`=1 and square f presents `move_valid` with `move_from`=f and `move_to`=t. Both are held until `move_done`. After `move_done`, bit f of the mask is set and another aggressor search is requested.
- R7: An aggressor search answered with `gen_found`=0 sets bit t of the mask and requests a victim search.
- R8: A push while a move is held suspends the ply. A later pop re-presents the same move at the parent level. The parent's remaining move list is unchanged by the nesting.
- R9: A `ply_push` at level DEPTH leaves `level` and the held move unchanged. It sets `overflow`, which stays 1 until reset.
- R10: A `ply_pop` at level 1 returns to level 0 with no request. A `ply_pop` at level 0, or while a search is outstanding, is ignored. A `ply_push` wins over a `move_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ply_push | input | 1 | Enter a new, deeper ply |
| ply_pop | input | 1 | Leave the current ply |
| own_pieces | input | 64 | Squares holding pieces of the side to move |
| gen_req | output | 1 | Generator request pending |
| gen_find_agg | output | 1 | 0: victim search, 1: aggressor search |
| gen_mask | output | 64 | Disable word of the current ply |
| gen_target | output | 6 | Victim square for an aggressor search |
| gen_ack | input | 1 | Generator response strobe |
| gen_found | input | 1 | Response holds a square |
| gen_sq | input | 6 | Square returned by the generator |
| move_valid | output | 1 | A move is presented |
| move_from | output | 6 | Origin square of the move |
| move_to | output | 6 | Target square of the move |
| move_done | input | 1 | Move searched and unmade |
| exhausted | output | 1 | No further move in this ply |
| overflow | output | 1 | A push was refused at full depth |
| level | output | clog2(DEPTH+1) | Number of active plies |

## Verification
A single ply is enumerated on a board where two victims share attackers. That shows whether own-piece bits are re-enabled on each new victim or wrongly left masked. A child ply with a victim that has no attacker separates a correct direct return to victim search from a stray move. The parent is interrupted at its first move and resumed after the child finishes; its full move list must match an uninterrupted reference, which catches a lost or corrupted saved word. A chain of pushes up to and past the depth limit, unwound by pops from held moves, shows the overflow refusal and each level's restored move.

// File: rtl/mvseq_pkg.sv
package mvseq_pkg;
  localparam int SQ_W = 6;
  localparam int NSQ  = 1 << SQ_W;

  typedef logic [SQ_W-1:0] sq_t;
  typedef logic [NSQ-1:0]  board_t;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_SEEK_VIC  = 3'd1,
    PH_SEEK_ATK  = 3'd2,
    PH_HOLD_MOVE = 3'd3,
    PH_EMPTY     = 3'd4
  } phase_e;

  // Saved context of one ply: disable word, current victim, current attacker.
  typedef struct packed {
    board_t mask;
    sq_t    vic;
    sq_t    atk;
  } frame_t;
endpackage

// File: rtl/mvseq_sq_onehot.sv
module mvseq_sq_onehot
  import mvseq_pkg::*;
(
  input  sq_t    sq,
  output board_t hot
);
  for (genvar i = 0; i < NSQ; i++) begin : g_bit
    assign hot[i] = (sq == sq_t'(i));
  end
endmodule

// File: rtl/mvseq_frame_stack.sv
module mvseq_frame_stack
  import mvseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  frame_t           wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output frame_t           rd_data
);
  frame_t slot [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (wr_en) begin
      slot[wr_idx] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/mvseq_ctrl.sv
module mvseq_ctrl
  import mvseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ply_push,
  input  logic             ply_pop,
  input  logic             move_done,
  input  logic             gen_ack,
  input  logic             gen_found,
  input  sq_t              gen_sq,
  input  board_t           own_pieces,
  input  board_t           vic_hot,
  input  board_t           atk_hot,
  input  frame_t           rd_frame,
  output phase_e           ph,
  output logic [LVL_W-1:0] lvl,
  output frame_t           cur,
  output logic             ovf,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx
);
  phase_e           ph_n;
  logic [LVL_W-1:0] lvl_n;
  frame_t           cur_n;
  logic             ph_we, lvl_we, cur_we, ovf_set;
  logic             push_ok, pop_ok;

  // Parent context goes to slot level-1 on push, returns from slot level-2 on pop.
  assign wr_idx = IDX_W'(lvl) - IDX_W'(1);
  assign rd_idx = IDX_W'(lvl) - IDX_W'(2);

  assign push_ok = ply_push && (ph == PH_IDLE || ph == PH_HOLD_MOVE);
  assign pop_ok  = ply_pop  && (ph == PH_HOLD_MOVE || ph == PH_EMPTY);

  always_comb begin
    ph_n    = ph;
    lvl_n   = lvl;
    cur_n   = cur;
    ph_we   = 1'b0;
    lvl_we  = 1'b0;
    cur_we  = 1'b0;
    ovf_set = 1'b0;
    wr_en   = 1'b0;
    if (push_ok) begin
      if (lvl == LVL_W'(DEPTH)) begin
        ovf_set = 1'b1;
      end else begin
        wr_en      = (lvl != '0);
        lvl_n      = lvl + LVL_W'(1);
        lvl_we     = 1'b1;
        cur_n.mask = '0;
        cur_we     = 1'b1;
        ph_n       = PH_SEEK_VIC;
        ph_we      = 1'b1;
      end
    end else if (pop_ok) begin
      lvl_n  = lvl - LVL_W'(1);
      lvl_we = 1'b1;
      ph_we  = 1'b1;
      if (lvl == LVL_W'(1)) begin
        ph_n = PH_IDLE;
      end else begin
        cur_n  = rd_frame;
        cur_we = 1'b1;
        ph_n   = PH_HOLD_MOVE;
      end
    end else begin
      unique case (ph)
        PH_SEEK_VIC: if (gen_ack) begin
          ph_we = 1'b1;
          if (gen_found) begin
            cur_n.mask = cur.mask & ~own_pieces;
            cur_n.vic  = gen_sq;
            cur_we     = 1'b1;
            ph_n       = PH_SEEK_ATK;
          end else begin
            ph_n = PH_EMPTY;
          end
        end
        PH_SEEK_ATK: if (gen_ack) begin
          ph_we  = 1'b1;
          cur_we = 1'b1;
          if (gen_found) begin
            cur_n.atk = gen_sq;
            ph_n      = PH_HOLD_MOVE;
          end else begin
            cur_n.mask = cur.mask | vic_hot;
            ph_n       = PH_SEEK_VIC;
          end
        end
        PH_HOLD_MOVE: if (move_done) begin
          cur_n.mask = cur.mask | atk_hot;
          cur_we     = 1'b1;
          ph_n       = PH_SEEK_ATK;
          ph_we      = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      lvl <= '0;
      cur <= '0;
      ovf <= 1'b0;
    end else begin
      if (ph_we)   ph  <= ph_n;
      if (lvl_we)  lvl <= lvl_n;
      if (cur_we)  cur <= cur_n;
      if (ovf_set) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ply_move_sequencer.sv
module ply_move_sequencer
  import mvseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ply_push,
  input  logic             ply_pop,
  input  logic [NSQ-1:0]   own_pieces,
  output logic             gen_req,
  output logic             gen_find_agg,
  output logic [NSQ-1:0]   gen_mask,
  output logic [SQ_W-1:0]  gen_target,
  input  logic             gen_ack,
  input  logic             gen_found,
  input  logic [SQ_W-1:0]  gen_sq,
  output logic             move_valid,
  output logic [SQ_W-1:0]  move_from,
  output logic [SQ_W-1:0]  move_to,
  input  logic             move_done,
  output logic             exhausted,
  output logic             overflow,
  output logic [LVL_W-1:0] level
);
  phase_e           ph;
  frame_t           cur, rd_frame;
  board_t           vic_hot, atk_hot;
  logic             wr_en, ovf;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [LVL_W-1:0] lvl;

  mvseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ply_push(ply_push), .ply_pop(ply_pop),
    .move_done(move_done), .gen_ack(gen_ack), .gen_found(gen_found),
    .gen_sq(gen_sq), .own_pieces(own_pieces), .vic_hot(vic_hot),
    .atk_hot(atk_hot), .rd_frame(rd_frame), .ph(ph), .lvl(lvl), .cur(cur),
    .ovf(ovf), .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  mvseq_frame_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(cur), .rd_idx(rd_idx), .rd_data(rd_frame)
  );

  mvseq_sq_onehot u_vic_dec (.sq(cur.vic), .hot(vic_hot));
  mvseq_sq_onehot u_atk_dec (.sq(cur.atk), .hot(atk_hot));

  assign gen_req      = (ph == PH_SEEK_VIC) || (ph == PH_SEEK_ATK);
  assign gen_find_agg = (ph == PH_SEEK_ATK);
  assign gen_mask     = cur.mask;
  assign gen_target   = cur.vic;
  assign move_valid   = (ph == PH_HOLD_MOVE);
  assign move_from    = cur.atk;
  assign move_to      = cur.vic;
  assign exhausted    = (ph == PH_EMPTY);
  assign overflow     = ovf;
  assign level        = lvl;
endmodule

// File: rtl/ply_move_sequencer_chk.sv
module ply_move_sequencer_chk
  import mvseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ply_push,
  input logic             ply_pop,
  input logic [NSQ-1:0]   own_pieces,
  input logic             gen_req,
  input logic             gen_find_agg,
  input logic [NSQ-1:0]   gen_mask,
  input logic [SQ_W-1:0]  gen_target,
  input logic             gen_ack,
  input logic             gen_found,
  input logic [SQ_W-1:0]  gen_sq,
  input logic             move_valid,
  input logic [SQ_W-1:0]  move_from,
  input logic [SQ_W-1:0]  move_to,
  input logic             move_done,
  input logic             exhausted,
  input logic             overflow,
  input logic [LVL_W-1:0] level
);
  a_r2_push_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ply_push && level == '0) |=> (gen_req && !gen_find_agg && gen_mask == '0 && level == LVL_W'(1)));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && !gen_ack) |=> (gen_req && $stable(gen_find_agg) && $stable(gen_mask)));

  a_r4_exhaust_held: assert property (@(posedge clk) disable iff (!rst_n)
    (exhausted && !ply_pop) |=> exhausted);

  a_r5_victim_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && !gen_find_agg && gen_ack && gen_found) |=>
      (gen_find_agg && gen_target == $past(gen_sq) &&
       gen_mask == ($past(gen_mask) & ~$past(own_pieces))));

  a_r6_move_held: assert property (@(posedge clk) disable iff (!rst_n)
    (move_valid && !move_done && !ply_push && !ply_pop) |=>
      (move_valid && $stable(move_from) && $stable(move_to)));

  a_r6_origin_retired: assert property (@(posedge clk) disable iff (!rst_n)
    (move_valid && move_done && !ply_push && !ply_pop) |=>
      (gen_req && gen_find_agg &&
       gen_mask == ($past(gen_mask) | (NSQ'(1) << $past(move_from)))));

  a_r7_victim_retired: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && gen_find_agg && gen_ack && !gen_found) |=>
      (gen_req && !gen_find_agg &&
       gen_mask == ($past(gen_mask) | (NSQ'(1) << $past(gen_target)))));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
endmodule

bind ply_move_sequencer ply_move_sequencer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ply_push(ply_push), .ply_pop(ply_pop),
  .own_pieces(own_pieces), .gen_req(gen_req), .gen_find_agg(gen_find_agg),
  .gen_mask(gen_mask), .gen_target(gen_target), .gen_ack(gen_ack),
  .gen_found(gen_found), .gen_sq(gen_sq), .move_valid(move_valid),
  .move_from(move_from), .move_to(move_to), .move_done(move_done),
  .exhausted(exhausted), .overflow(overflow), .level(level)
);

// File: tb/test_ply_move_sequencer.sv
module test_ply_move_sequencer;
  localparam int DEPTH = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [63:0] OWN = 64'h0000_0000_0000_FFFF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ply_push, ply_pop, gen_ack, gen_found, move_done;
  logic [63:0] own_pieces;
  logic [5:0]  gen_sq;
  logic gen_req, gen_find_agg, move_valid, exhausted, overflow;
  logic [63:0] gen_mask;
  logic [5:0]  gen_target, move_from, move_to;
  logic [LVL_W-1:0] level;

  ply_move_sequencer #(.DEPTH(DEPTH)) i_ply_move_sequencer (
    .clk(clk), .rst_n(rst_n), .ply_push(ply_push), .ply_pop(ply_pop),
    .own_pieces(own_pieces), .gen_req(gen_req), .gen_find_agg(gen_find_agg),
    .gen_mask(gen_mask), .gen_target(gen_target), .gen_ack(gen_ack),
    .gen_found(gen_found), .gen_sq(gen_sq), .move_valid(move_valid),
    .move_from(move_from), .move_to(move_to), .move_done(move_done),
    .exhausted(exhausted), .overflow(overflow), .level(level)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Board per level: victim squares and attacker base set.
  logic [63:0] vic [0:DEPTH+1];
  logic [63:0] att [0:DEPTH+1];

  function automatic int lowbit(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [63:0] atk_of(input int l, input int t);
    return (att[l] >> (t % 3)) & OWN;
  endfunction

  // Generator model: answers each request after two cycles.
  int gcnt;
  always @(negedge clk) begin
    int r;
    if (!rst_n) begin
      gen_ack = 1'b0; gcnt = 0;
    end else if (gen_ack) begin
      gen_ack = 1'b0; gcnt = 0;
    end else if (gen_req) begin
      if (gcnt == 1) begin
        if (!gen_find_agg) r = lowbit(vic[int'(level)] & ~gen_mask);
        else               r = lowbit(atk_of(int'(level), int'(gen_target)) & ~gen_mask);
        gen_ack   = 1'b1;
        gen_found = (r >= 0);
        gen_sq    = (r >= 0) ? 6'(r) : 6'd63;
      end else gcnt++;
    end else gcnt = 0;
  end

  // Behavioural reference model, stepped on every clock.
  int m_ph, m_lvl, m_to, m_from;
  bit m_ovf;
  logic [63:0] m_mask;
  logic [63:0] sm [$];
  int sto [$];
  int sfr [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_lvl = 0; m_mask = '0; m_to = 0; m_from = 0; m_ovf = 0;
      sm.delete(); sto.delete(); sfr.delete();
    end else if (ply_push && (m_ph == 0 || m_ph == 3)) begin
      if (m_lvl == DEPTH) m_ovf = 1;
      else begin
        if (m_lvl > 0) begin sm.push_back(m_mask); sto.push_back(m_to); sfr.push_back(m_from); end
        m_lvl++; m_mask = '0; m_ph = 1;
      end
    end else if (ply_pop && (m_ph == 3 || m_ph == 4)) begin
      m_lvl--;
      if (m_lvl == 0) m_ph = 0;
      else begin m_mask = sm.pop_back(); m_to = sto.pop_back(); m_from = sfr.pop_back(); m_ph = 3; end
    end else begin
      case (m_ph)
        1: if (gen_ack) begin
             if (gen_found) begin m_mask = m_mask & ~own_pieces; m_to = int'(gen_sq); m_ph = 2; end
             else m_ph = 4;
           end
        2: if (gen_ack) begin
             if (gen_found) begin m_from = int'(gen_sq); m_ph = 3; end
             else begin m_mask[m_to] = 1'b1; m_ph = 1; end
           end
        3: if (move_done) begin m_mask[m_from] = 1'b1; m_ph = 2; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(gen_req == (m_ph == 1 || m_ph == 2), "R3", "gen_req", 64'(gen_req), 64'(m_ph == 1 || m_ph == 2));
      check(exhausted == (m_ph == 4), "R4", "exhausted", 64'(exhausted), 64'(m_ph == 4));
      check(move_valid == (m_ph == 3), "R6", "move_valid", 64'(move_valid), 64'(m_ph == 3));
      check(int'(level) == m_lvl, "R8", "level", 64'(level), 64'(m_lvl));
      check(overflow == m_ovf, "R9", "overflow", 64'(overflow), 64'(m_ovf));
      if (m_ph == 1 || m_ph == 2)
        check(gen_mask == m_mask && gen_find_agg == (m_ph == 2), "R5", "gen_mask", gen_mask, m_mask);
      if (m_ph == 2)
        check(int'(gen_target) == m_to, "R5", "gen_target", 64'(gen_target), 64'(m_to));
      if (m_ph == 3)
        check(int'(move_from) == m_from && int'(move_to) == m_to, "R6", "move pair",
              64'(move_from * 64 + move_to), 64'(m_from * 64 + m_to));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  int exp_q [$];
  int got_q [$];

  task automatic build_ref(input int l);
    logic [63:0] m;
    int t, f;
    m = '0;
    exp_q.delete();
    while (1) begin
      t = lowbit(vic[l] & ~m);
      if (t < 0) break;
      m = m & ~OWN;
      while (1) begin
        f = lowbit(atk_of(l, t) & ~m);
        if (f < 0) break;
        exp_q.push_back(f * 64 + t);
        m[f] = 1'b1;
      end
      m[t] = 1'b1;
    end
  endtask

  task automatic collect();
    while (1) begin
      while (!(move_valid || exhausted)) @(negedge clk);
      if (exhausted) break;
      got_q.push_back(int'(move_from) * 64 + int'(move_to));
      move_done = 1'b1;
      @(negedge clk);
      move_done = 1'b0;
    end
  endtask

  task automatic compare_lists(input string tag);
    check(got_q.size() == exp_q.size(), tag, "move count", 64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], tag, "move order", 64'(got_q[i]), 64'(exp_q[i]));
  endtask

  task automatic pulse_push();
    ply_push = 1'b1; @(negedge clk); ply_push = 1'b0;
  endtask

  task automatic pulse_pop();
    ply_pop = 1'b1; @(negedge clk); ply_pop = 1'b0;
  endtask

  task automatic wait_move();
    while (!move_valid) @(negedge clk);
  endtask

  initial begin
    int f0, t0;
    rst_n = 1'b0; ply_push = 1'b0; ply_pop = 1'b0; move_done = 1'b0;
    gen_found = 1'b0; gen_sq = '0; own_pieces = OWN;
    vic[0] = '0; att[0] = '0;
    vic[1] = (64'd1 << 40) | (64'd1 << 45) | (64'd1 << 50);
    att[1] = (64'd1 << 3) | (64'd1 << 7) | (64'd1 << 12) | (64'd1 << 13);
    vic[2] = (64'd1 << 33) | (64'd1 << 41) | (64'd1 << 63);
    att[2] = (64'd1 << 0) | (64'd1 << 1);
    vic[3] = 64'd1 << 48; att[3] = 64'd1 << 5;
    vic[4] = 64'd1 << 56; att[4] = 64'd1 << 2;
    vic[5] = '0; att[5] = '0;

    repeat (3) @(negedge clk);
    check(level == '0 && !gen_req && !move_valid && !exhausted && !overflow, "R1", "reset state",
          {gen_req, move_valid, exhausted, overflow}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!gen_req && level == '0, "R1", "idle after release", 64'(gen_req), 64'd0);

    // R10: pop at level 0 is ignored
    pulse_pop();
    check(level == '0 && !gen_req, "R10", "pop at level 0", 64'(level), 64'd0);

    // Single ply enumeration (R2, R5, R6, R7, R4)
    pulse_push();
    check(gen_req && !gen_find_agg && gen_mask == '0 && level == LVL_W'(1), "R2", "push start",
          {gen_mask[61:0], gen_find_agg, gen_req}, 64'd1);
    pulse_pop();
    check(level == LVL_W'(1) && gen_req, "R10", "pop during search", 64'(level), 64'd1);
    got_q.delete();
    collect();
    build_ref(1);
    compare_lists("R5");
    repeat (3) @(negedge clk);
    check(exhausted && !gen_req, "R4", "exhausted held", 64'(exhausted), 64'd1);
    pulse_pop();
    check(level == '0 && !exhausted && !gen_req, "R10", "pop to idle", 64'(level), 64'd0);

    // Nested plies (R8, R7 via a victim with no attacker)
    pulse_push();
    wait_move();
    f0 = int'(move_from); t0 = int'(move_to);
    pulse_push();
    check(level == LVL_W'(2) && gen_req && gen_mask == '0, "R8", "child entered", 64'(level), 64'd2);
    got_q.delete();
    collect();
    build_ref(2);
    compare_lists("R7");
    pulse_pop();
    check(move_valid && int'(move_from) == f0 && int'(move_to) == t0 && level == LVL_W'(1), "R8",
          "parent move restored", 64'(move_from * 64 + move_to), 64'(f0 * 64 + t0));
    got_q.delete();
    got_q.push_back(f0 * 64 + t0);
    move_done = 1'b1; @(negedge clk); move_done = 1'b0;
    collect();
    build_ref(1);
    compare_lists("R8");
    pulse_pop();

    // Depth limit (R9) and unwinding
    pulse_push();
    for (int l = 1; l < DEPTH; l++) begin
      wait_move();
      pulse_push();
    end
    wait_move();
    f0 = int'(move_from); t0 = int'(move_to);
    pulse_push();
    check(overflow, "R9", "overflow set", 64'(overflow), 64'd1);
    check(level == LVL_W'(DEPTH) && move_valid && int'(move_from) == f0 && int'(move_to) == t0, "R9",
          "push refused", 64'(level), 64'(DEPTH));
    for (int l = DEPTH; l > 0; l--) begin
      wait_move();
      pulse_pop();
      check(int'(level) == l - 1, "R8", "unwind level", 64'(level), 64'(l - 1));
    end
    check(overflow && !gen_req && !move_valid, "R9", "overflow sticky", 64'(overflow), 64'd1);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule